// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 64-bit virtual address into a physical address. A request carries the virtual address, the kind of access (read, write or execute) and the privilege mode of the requester. If the address lies in the fixed kernel superpage, the block maps it directly and does no memory reads. Otherwise it reads one entry from each of three table levels through a single-beat memory read port. It starts from the table base given on its own input. It finishes each request with a one-cycle completion pulse. That pulse carries either the physical address and the granted permissions, or a fault code.

Pages are 8 KiB, so the page offset is 13 bits. Each level index is 10 bits wide and each table entry is 8 bytes. Only one memory read is in flight at a time. A new request is taken only while the walker is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset the walker is idle: `reqReady` is 1, while `memReqValid` and `doneValid` are 0.
- R2: If virtual bits 63:43 are not all equal, the request completes with fault code 1 (access violation). No memory read is made, and `doneValid` rises in the cycle after acceptance.
- R3: Kernel mode (`reqMode` 0) may use the superpage. An address in the superpage has bits 63:43 all ones and bits 42:41 equal to binary 10. For such a request the block makes no memory read and completes in the cycle after acceptance. It returns fault code 0, permissions 3'b111 and a physical address made of virtual bits 39:0, with virtual bit 40 copied to physical bit 43.
- R4: A superpage address requested in any mode other than 0 completes with fault code 1 after no memory read.
- R5: The first read goes to `ptBase` plus 8 times virtual bits 42:33. The second read goes to the level-1 base plus 8 times bits 32:23, and the third to the level-2 base plus 8 times bits 22:13. Each next base is entry bits 63:32 shifted left by 13.
- R6: A level-1 or level-2 entry whose bit 0 (valid) is 0, or whose bit 8 (kernel read enable) is 0, ends the walk at once with fault code 2 (not valid). No further read is made.
- R7: A level-3 entry with bit 0 clear completes with fault code 2.
- R8: At level 3, read enable is entry bit 8+mode and write enable is entry bit 12+mode. A read enable grants both read and execute. If the requested access (`reqAccess` 0 read, 1 write, 2 execute) is not granted, the fault code is 1.
- R9: Entry bits 1, 2 and 3 withdraw read, write and execute. A granted access that this withdraws gives fault code 3 for a read, 4 for a write and 5 for an execute.
- R10: A successful walk returns fault code 0. Its physical address is entry bits 63:32 shifted left by 13, ORed with virtual bits 12:0. Its permissions (`donePerm` bit 0 read, bit 1 write, bit 2 execute) are those left after withdrawal. Every fault returns zero address and zero permissions.
- R11: `memReqValid` holds with a stable address until `memReqReady`. A new read is issued only after the previous response. `reqReady` stays low from acceptance until after completion, and `doneValid` lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Translation request present |
| reqReady | output | 1 | Walker idle and taking a request |
| reqVaddr | input | 64 | Virtual address to translate |
| reqAccess | input | 2 | 0 read, 1 write, 2 execute |
| reqMode | input | 2 | Privilege mode, 0 is kernel |
| ptBase | input | 64 | Level-1 table base address |
| memReqValid | output | 1 | Table read request |
| memReqReady | input | 1 | Memory takes the read |
| memReqAddr | output | 64 | Byte address of the table entry |
| memRspValid | input | 1 | Read data returned (one-cycle pulse) |
| memRspData | input | 64 | Table entry |
| doneValid | output | 1 | One-cycle completion pulse |
| donePaddr | output | 64 | Physical address |
| donePerm | output | 3 | Granted permissions: bit 0 read, 1 write, 2 execute |
| doneFault | output | 3 | 0 none, 1 access violation, 2 not valid, 3/4/5 withdrawn read/write/execute |

## Verification
The assertions assume that `memRspValid` is pulsed only once per accepted read, and only after that read has been taken. They also assume that `reqAccess` stays within the three defined access codes, because the check that the requested access was granted decodes it. The bench memory model answers each handshake exactly once, after a delay of zero to two idle cycles, and it varies `memReqReady` pseudo-randomly. The driver uses only access codes 0 to 2 and waits for idle before it offers each request.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  // Page table entry field positions that the walk decodes
  localparam int PTE_VALID   = 0;
  localparam int PTE_FO_LSB  = 1;   // withdraw bits for read, write, execute
  localparam int PTE_RE_BASE = 8;   // read enable, indexed by mode
  localparam int PTE_WE_BASE = 12;  // write enable, indexed by mode

  // Superpage decode and relocation
  localparam int SP_TAG_HI  = 42;
  localparam int SP_TAG_LO  = 41;
  localparam int SP_SRC_BIT = 40;
  localparam int SP_DST_BIT = 43;

  localparam logic [1:0] MODE_KERNEL = 2'd0;

  typedef enum logic [2:0] {
    FLT_NONE = 3'd0,
    FLT_ACV  = 3'd1,
    FLT_TNV  = 3'd2,
    FLT_FOR  = 3'd3,
    FLT_FOW  = 3'd4,
    FLT_FOE  = 3'd5
  } fault_e;

  typedef enum logic [1:0] {
    LVL_1 = 2'd0,
    LVL_2 = 2'd1,
    LVL_3 = 2'd2
  } level_e;

  typedef struct packed {
    logic   latchReq;
    logic   nextTable;
    logic   stopUpper;
    logic   finishLeaf;
    level_e lvl;
  } strobe_t;

  // One-hot need: bit 0 read, bit 1 write, bit 2 execute
  function automatic logic [2:0] accessNeed(input logic [1:0] acc);
    case (acc)
      2'd0:    return 3'b001;
      2'd1:    return 3'b010;
      default: return 3'b100;
    endcase
  endfunction

endpackage

// File: rtl/pt_walker_ctrl.sv
module pt_walker_ctrl
  import pt_walker_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    earlyExit,
  input  logic    upperBad,
  input  logic    memReqReady,
  input  logic    memRspValid,
  output logic    reqReady,
  output logic    memReqValid,
  output logic    doneValid,
  output strobe_t stb
);

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_L1,
    ST_L2,
    ST_L3,
    ST_DONE
  } state_e;

  state_e stateQ, stateD;
  logic   waitRsp;
  logic   walking;
  logic   rspHit;

  assign walking     = (stateQ == ST_L1) || (stateQ == ST_L2) || (stateQ == ST_L3);
  assign reqReady    = (stateQ == ST_IDLE);
  assign memReqValid = walking && !waitRsp;
  assign doneValid   = (stateQ == ST_DONE);
  assign rspHit      = walking && waitRsp && memRspValid;

  always_comb begin
    stb           = '0;
    stateD        = stateQ;
    stb.latchReq  = (stateQ == ST_IDLE) && reqValid;
    unique case (stateQ)
      ST_L2:   stb.lvl = LVL_2;
      ST_L3:   stb.lvl = LVL_3;
      default: stb.lvl = LVL_1;
    endcase
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) stateD = earlyExit ? ST_DONE : ST_L1;
      end
      ST_L1, ST_L2: begin
        if (rspHit) begin
          if (upperBad) begin
            stb.stopUpper = 1'b1;
            stateD        = ST_DONE;
          end else begin
            stb.nextTable = 1'b1;
            stateD        = (stateQ == ST_L1) ? ST_L2 : ST_L3;
          end
        end
      end
      ST_L3: begin
        if (rspHit) begin
          stb.finishLeaf = 1'b1;
          stateD         = ST_DONE;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ  <= ST_IDLE;
      waitRsp <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (rspHit)
        waitRsp <= 1'b0;
      else if (memReqValid && memReqReady)
        waitRsp <= 1'b1;
    end
  end

endmodule

// File: rtl/pt_walker_dp.sv
module pt_walker_dp
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_BITS  = 13,
  parameter int VA_IMPL    = 43,
  parameter int IDX_BITS   = 10,
  parameter int NUM_LEVELS = 3,
  parameter int FRAME_LSB  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic [1:0]        reqMode,
  input  logic [ADDR_W-1:0] ptBase,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              earlyExit,
  output logic              upperBad,
  output logic [ADDR_W-1:0] memReqAddr,
  output logic [ADDR_W-1:0] donePaddr,
  output logic [2:0]        donePerm,
  output fault_e            doneFault
);

  localparam int HI_W       = ADDR_W - VA_IMPL;
  localparam int VA_USED    = PAGE_BITS + NUM_LEVELS * IDX_BITS;
  localparam int ENTRY_LOG2 = 3;

  logic [VA_USED-1:0] vaQ;
  logic [2:0]         needQ;
  logic [1:0]         modeQ;
  logic [ADDR_W-1:0]  baseQ;

  // Request-side decode
  logic              signOk;
  logic              superHit;
  logic [ADDR_W-1:0] spPaddr;

  assign signOk    = (reqVaddr[ADDR_W-1:VA_IMPL] == {HI_W{reqVaddr[ADDR_W-1]}});
  assign superHit  = reqVaddr[ADDR_W-1] && (reqVaddr[SP_TAG_HI:SP_TAG_LO] == 2'b10);
  assign earlyExit = !signOk || superHit;
  assign spPaddr   = ADDR_W'(reqVaddr[SP_SRC_BIT-1:0])
                   | (ADDR_W'(reqVaddr[SP_SRC_BIT]) << SP_DST_BIT);

  // Per-level index fields, highest level first
  logic [IDX_BITS-1:0] lvlIdx [NUM_LEVELS];
  for (genvar g = 0; g < NUM_LEVELS; g++) begin : g_idx
    localparam int LSB = PAGE_BITS + (NUM_LEVELS - 1 - g) * IDX_BITS;
    assign lvlIdx[g] = vaQ[LSB +: IDX_BITS];
  end

  logic [IDX_BITS-1:0] selIdx;
  always_comb begin
    unique case (stb.lvl)
      LVL_1:   selIdx = lvlIdx[0];
      LVL_2:   selIdx = lvlIdx[1];
      default: selIdx = lvlIdx[NUM_LEVELS-1];
    endcase
  end

  assign memReqAddr = baseQ + (ADDR_W'(selIdx) << ENTRY_LOG2);

  // Entry decode
  logic [ADDR_W-1:0] nextBase;
  assign nextBase = ADDR_W'(memRspData[ADDR_W-1:FRAME_LSB]) << PAGE_BITS;
  assign upperBad = !memRspData[PTE_VALID] || !memRspData[PTE_RE_BASE];

  logic       leafRe;
  logic       leafWe;
  logic [2:0] grant;
  logic [2:0] kept;
  fault_e     leafFault;

  assign leafRe = memRspData[PTE_RE_BASE + int'(modeQ)];
  assign leafWe = memRspData[PTE_WE_BASE + int'(modeQ)];
  assign grant  = {leafRe, leafWe, leafRe};
  assign kept   = grant & ~memRspData[PTE_FO_LSB +: 3];

  always_comb begin
    if (!memRspData[PTE_VALID])
      leafFault = FLT_TNV;
    else if ((grant & needQ) == 3'b000)
      leafFault = FLT_ACV;
    else if ((kept & needQ) == 3'b000) begin
      if (needQ[2])      leafFault = FLT_FOE;
      else if (needQ[1]) leafFault = FLT_FOW;
      else               leafFault = FLT_FOR;
    end else
      leafFault = FLT_NONE;
  end

  logic unusedRspBits;
  assign unusedRspBits = ^{memRspData[FRAME_LSB-1:PTE_WE_BASE+4],
                           memRspData[PTE_RE_BASE-1:PTE_FO_LSB+3]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      vaQ       <= '0;
      needQ     <= '0;
      modeQ     <= '0;
      baseQ     <= '0;
      donePaddr <= '0;
      donePerm  <= '0;
      doneFault <= FLT_NONE;
    end else begin
      if (stb.latchReq) begin
        vaQ   <= reqVaddr[VA_USED-1:0];
        needQ <= accessNeed(reqAccess);
        modeQ <= reqMode;
        baseQ <= ptBase;
        if (!signOk || (superHit && reqMode != MODE_KERNEL)) begin
          doneFault <= FLT_ACV;
          donePaddr <= '0;
          donePerm  <= '0;
        end else if (superHit) begin
          doneFault <= FLT_NONE;
          donePaddr <= spPaddr;
          donePerm  <= 3'b111;
        end
      end
      if (stb.nextTable)
        baseQ <= nextBase;
      if (stb.stopUpper) begin
        doneFault <= FLT_TNV;
        donePaddr <= '0;
        donePerm  <= '0;
      end
      if (stb.finishLeaf) begin
        doneFault <= leafFault;
        if (leafFault == FLT_NONE) begin
          donePaddr <= nextBase | ADDR_W'(vaQ[PAGE_BITS-1:0]);
          donePerm  <= kept;
        end else begin
          donePaddr <= '0;
          donePerm  <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W    = 64,
  parameter int PAGE_BITS = 13,
  parameter int VA_IMPL   = 43,
  parameter int IDX_BITS  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqVaddr,
  input  logic [1:0]        reqAccess,
  input  logic [1:0]        reqMode,
  input  logic [ADDR_W-1:0] ptBase,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              memRspValid,
  input  logic [ADDR_W-1:0] memRspData,
  output logic              doneValid,
  output logic [ADDR_W-1:0] donePaddr,
  output logic [2:0]        donePerm,
  output logic [2:0]        doneFault
);

  strobe_t stb;
  logic    earlyExit;
  logic    upperBad;
  fault_e  faultQ;

  pt_walker_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .earlyExit  (earlyExit),
    .upperBad   (upperBad),
    .memReqReady(memReqReady),
    .memRspValid(memRspValid),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .doneValid  (doneValid),
    .stb        (stb)
  );

  pt_walker_dp #(
    .ADDR_W   (ADDR_W),
    .PAGE_BITS(PAGE_BITS),
    .VA_IMPL  (VA_IMPL),
    .IDX_BITS (IDX_BITS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .reqVaddr  (reqVaddr),
    .reqAccess (reqAccess),
    .reqMode   (reqMode),
    .ptBase    (ptBase),
    .memRspData(memRspData),
    .earlyExit (earlyExit),
    .upperBad  (upperBad),
    .memReqAddr(memReqAddr),
    .donePaddr (donePaddr),
    .donePerm  (donePerm),
    .doneFault (faultQ)
  );

  assign doneFault = faultQ;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [1:0]        reqAccess,
  input logic              memReqValid,
  input logic              memReqReady,
  input logic [ADDR_W-1:0] memReqAddr,
  input logic              doneValid,
  input logic [ADDR_W-1:0] donePaddr,
  input logic [2:0]        donePerm,
  input logic [2:0]        doneFault
);

  logic [2:0] needSeen;

  always_ff @(posedge clk) begin
    if (!rstN)
      needSeen <= '0;
    else if (reqValid && reqReady)
      needSeen <= accessNeed(reqAccess);
  end

  p_busy_blocks_req_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid || doneValid) |-> !reqReady);

  p_read_held_r11: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> (memReqValid && $stable(memReqAddr)));

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  p_fault_zeroes_r10: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneFault != 3'd0) |-> (donePerm == 3'b000 && donePaddr == '0));

  p_need_granted_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneFault == 3'd0) |-> ((donePerm & needSeen) != 3'b000));

  p_fault_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneFault <= 3'd5));

endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .reqValid   (reqValid),
  .reqReady   (reqReady),
  .reqAccess  (reqAccess),
  .memReqValid(memReqValid),
  .memReqReady(memReqReady),
  .memReqAddr (memReqAddr),
  .doneValid  (doneValid),
  .donePaddr  (donePaddr),
  .donePerm   (donePerm),
  .doneFault  (doneFault)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

  localparam int F_NONE = 0, F_ACV = 1, F_TNV = 2, F_FOR = 3, F_FOW = 4, F_FOE = 5;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [63:0] reqVaddr = '0;
  logic [1:0]  reqAccess = '0;
  logic [1:0]  reqMode = '0;
  logic [63:0] ptBase = '0;
  logic        memReqValid;
  logic        memReqReady = 1'b0;
  logic [63:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        doneValid;
  logic [63:0] donePaddr;
  logic [2:0]  donePerm;
  logic [2:0]  doneFault;

  always #2 clk = ~clk;

  pt_walker u_pt_walker (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqVaddr(reqVaddr),
    .reqAccess(reqAccess), .reqMode(reqMode), .ptBase(ptBase),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .doneValid(doneValid), .donePaddr(donePaddr), .donePerm(donePerm),
    .doneFault(doneFault)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [63:0] paddr;
    logic [2:0]  perm;
    int          fault;
    bit          early;
    string       tag;
  } exp_t;

  exp_t        expQ[$];
  logic [63:0] addrQ[$];
  logic [63:0] memArr [logic [63:0]];

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd(input logic [63:0] a);
    if (memArr.exists(a)) return memArr[a];
    return 64'h0;
  endfunction

  // Memory responder: one response per handshake, 0..2 idle cycles later
  logic [7:0]  lfsr = 8'hA5;
  bit          hsPrev = 0;
  logic [63:0] hsAddr = '0;
  bit          pend = 0;
  int          cnt = 0;
  logic [63:0] pendAddr = '0;

  always @(negedge clk) begin
    if (memRspValid) memRspValid = 1'b0;
    if (hsPrev) begin
      logic [63:0] want;
      want = (addrQ.size() > 0) ? addrQ.pop_front() : 64'hDEAD_DEAD_DEAD_DEAD;
      check(hsAddr == want, "R5", "table read address", hsAddr, want);
      pendAddr = hsAddr;
      cnt = int'(lfsr[1:0]) % 3;
      pend = 1;
    end
    if (pend) begin
      if (cnt == 0) begin
        memRspValid = 1'b1;
        memRspData  = rd(pendAddr);
        pend = 0;
      end else cnt--;
    end
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    memReqReady = lfsr[0] | lfsr[3];
    hsPrev = memReqValid && memReqReady;
    hsAddr = memReqAddr;
  end

  // Monitor: pops expected results when completions appear
  bit inFlight = 0;
  int lat = 0;
  bit readyLeak = 0;
  bit prevDone = 0;

  always @(negedge clk) begin
    if (rstN) begin
      if (prevDone)
        check(!doneValid, "R11", "done pulse width", 64'(doneValid), 64'd0);
      prevDone = doneValid;
      if (doneValid && !inFlight)
        check(0, "R11", "unexpected completion", 64'd1, 64'd0);
      if (inFlight) begin
        lat++;
        if (!doneValid && reqReady) readyLeak = 1;
        if (doneValid) begin
          exp_t e;
          e = expQ.pop_front();
          check(int'(doneFault) == e.fault, e.tag, "fault code", 64'(doneFault), 64'(e.fault));
          check(donePaddr == e.paddr, e.tag, "physical address", donePaddr, e.paddr);
          check(donePerm == e.perm, e.tag, "permissions", 64'(donePerm), 64'(e.perm));
          check(addrQ.size() == 0, e.tag, "reads left unissued", 64'(addrQ.size()), 64'd0);
          check(!readyLeak, "R11", "reqReady while busy", 64'(readyLeak), 64'd0);
          if (e.early)
            check(lat == 1, e.tag, "early completion latency", 64'(lat), 64'd1);
          inFlight = 0;
        end
      end
      if (reqValid && reqReady) begin
        inFlight = 1;
        lat = 0;
        readyLeak = 0;
      end
    end
  end

  // Driver: builds the expected item from the requirements, then issues
  task automatic runReq(input logic [63:0] va, input logic [1:0] acc,
                        input logic [1:0] mode, input logic [63:0] base,
                        input string tag);
    exp_t        e;
    logic [2:0]  need;
    logic [63:0] tbl;
    e.paddr = '0; e.perm = '0; e.fault = F_NONE; e.early = 0; e.tag = tag;
    need = (acc == 2'd0) ? 3'b001 : (acc == 2'd1) ? 3'b010 : 3'b100;
    if (va[63:43] != {21{va[63]}}) begin
      e.fault = F_ACV; e.early = 1;
    end else if (va[63] && va[42:41] == 2'b10) begin
      e.early = 1;
      if (mode == 2'd0) begin
        e.paddr = {24'h0, va[39:0]};
        e.paddr[43] = va[40];
        e.perm = 3'b111;
      end else e.fault = F_ACV;
    end else begin
      tbl = base;
      for (int lv = 0; lv < 3; lv++) begin
        logic [63:0] a, pte;
        int sh;
        sh = 13 + (2 - lv) * 10;
        a = tbl + (((va >> sh) & 64'h3FF) << 3);
        addrQ.push_back(a);
        pte = rd(a);
        if (lv < 2) begin
          if (!pte[0] || !pte[8]) begin e.fault = F_TNV; break; end
          tbl = (pte >> 32) << 13;
        end else begin
          logic re, we;
          logic [2:0] g, k;
          re = pte[8 + mode];
          we = pte[12 + mode];
          g = {re, we, re};
          k = g & ~pte[3:1];
          if (!pte[0]) e.fault = F_TNV;
          else if ((g & need) == 0) e.fault = F_ACV;
          else if ((k & need) == 0)
            e.fault = (need == 3'b100) ? F_FOE : (need == 3'b010) ? F_FOW : F_FOR;
          else begin
            e.paddr = ((pte >> 32) << 13) | {51'h0, va[12:0]};
            e.perm = k;
          end
        end
      end
    end
    expQ.push_back(e);
    @(posedge clk); #1;
    while (!reqReady) begin @(posedge clk); #1; end
    reqValid = 1'b1; reqVaddr = va; reqAccess = acc; reqMode = mode; ptBase = base;
    @(posedge clk); #1;
    reqValid = 1'b0;
    while (!reqReady) begin @(posedge clk); #1; end
  endtask

  function automatic logic [63:0] mkva(input int i1, input int i2, input int k, input int off);
    return (64'(i1) << 33) | (64'(i2) << 23) | (64'(k) << 13) | 64'(off);
  endfunction

  localparam logic [63:0] BASE_A = 64'h0001_0000;
  localparam logic [63:0] BASE_B = 64'h0002_0000;
  localparam logic [63:0] L3T    = 64'h0008_2000;

  initial begin
    memArr[BASE_A + 64'h18] = {32'h40, 32'h0000_0101};
    memArr[BASE_B + 64'h18] = {32'h40, 32'h0000_0101};
    memArr[BASE_A + 64'h38] = {32'h50, 32'h0000_0100};   // valid clear
    memArr[64'h0008_0028]   = {32'h41, 32'h0000_0101};
    memArr[64'h0008_0030]   = {32'h42, 32'h0000_0001};   // kernel read clear
    memArr[L3T + 0*8] = {32'h123, 32'h0000_1101};
    memArr[L3T + 1*8] = {32'h124, 32'h0000_0801};
    memArr[L3T + 2*8] = {32'h125, 32'h0000_1105};
    memArr[L3T + 3*8] = {32'h126, 32'h0000_110B};
    memArr[L3T + 4*8] = {32'h127, 32'h0000_1100};
    memArr[L3T + 5*8] = {32'h128, 32'h0000_4201};

    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "reqReady after reset", 64'(reqReady), 64'd1);
    check(memReqValid == 1'b0, "R1", "memReqValid after reset", 64'(memReqValid), 64'd0);
    check(doneValid == 1'b0, "R1", "doneValid after reset", 64'(doneValid), 64'd0);

    runReq(64'h0000_1000_0000_0000, 2'd0, 2'd0, BASE_A, "R2");
    runReq(64'hFFFF_F000_0000_0000, 2'd1, 2'd0, BASE_A, "R2");
    runReq(64'hFFFF_FD12_3456_789A, 2'd0, 2'd0, BASE_A, "R3");
    runReq(64'hFFFF_FC00_0000_1234, 2'd2, 2'd0, BASE_A, "R3");
    runReq(64'hFFFF_FD12_3456_789A, 2'd0, 2'd3, BASE_A, "R4");
    runReq(64'hFFFF_FE00_0000_0000, 2'd0, 2'd0, BASE_A, "R6");
    runReq(mkva(3, 5, 0, 16'h0ABC), 2'd0, 2'd0, BASE_A, "R10");
    runReq(mkva(3, 5, 0, 16'h1FFF), 2'd1, 2'd0, BASE_B, "R5");
    runReq(mkva(3, 5, 0, 0), 2'd0, 2'd3, BASE_A, "R8");
    runReq(mkva(3, 5, 1, 8), 2'd1, 2'd3, BASE_A, "R8");
    runReq(mkva(3, 5, 1, 8), 2'd2, 2'd3, BASE_A, "R8");
    runReq(mkva(3, 5, 2, 4), 2'd1, 2'd0, BASE_A, "R9");
    runReq(mkva(3, 5, 2, 4), 2'd0, 2'd0, BASE_A, "R9");
    runReq(mkva(3, 5, 3, 2), 2'd2, 2'd0, BASE_A, "R9");
    runReq(mkva(3, 5, 3, 2), 2'd0, 2'd0, BASE_A, "R9");
    runReq(mkva(3, 5, 3, 2), 2'd1, 2'd0, BASE_A, "R9");
    runReq(mkva(3, 5, 4, 0), 2'd0, 2'd0, BASE_A, "R7");
    runReq(mkva(7, 5, 0, 0), 2'd0, 2'd0, BASE_A, "R6");
    runReq(mkva(3, 6, 0, 0), 2'd0, 2'd0, BASE_A, "R6");
    runReq(mkva(3, 5, 5, 5), 2'd0, 2'd1, BASE_A, "R8");
    runReq(mkva(3, 5, 5, 5), 2'd1, 2'd2, BASE_A, "R8");
    runReq(mkva(3, 5, 5, 5), 2'd0, 2'd2, BASE_A, "R8");
    for (int i = 0; i < 6; i++)
      runReq(mkva(3, 5, i, i * 37), 2'(i % 3), 2'd0, BASE_A, "R10");

    repeat (4) @(negedge clk);
    check(expQ.size() == 0, "R11", "completions outstanding", 64'(expQ.size()), 64'd0);
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL R11 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule